// File: doc/BRIEF.md
# External Memory Width Splitter

This block sits between an on-chip bus slave port and an external memory port. It accepts one bus transfer at a time. Each transfer is 8, 16 or 32 bits wide, is a read or a write, and comes with three settings: the kind of memory attached (NOR flash, PSRAM or SRAM/ROM), whether the memory is run synchronously, and whether the memory data path is 8 or 16 bits wide.

A supported transfer is broken into one, two or four external accesses, issued in ascending address order. For each access the block drives the address, the write data and active-low byte-lane enables. It collects the read data of every access into one little-endian bus word. A transfer that the selected memory cannot perform finishes at once with an error response and makes no external access.

Each external access is a plain handshake: the block holds its request until the memory model answers with an acknowledge in the same cycle. Setup, hold and wait-state timing is left to the memory side.

Top module: `extWidthSplitter`

## Requirements
- R1: After reset, reqReady is 1, memValid is 0 and respValid is 0.
- R2: The number of external accesses is set by bus size and memory width. 32-bit to a 16-bit memory makes 2 accesses. 32-bit to an 8-bit memory makes 4. 16-bit to an 8-bit memory makes 2. Every other supported case makes 1. The size codes are 0 = 8 bits, 1 = 16 bits and 2 = 32 bits. memWide = 1 selects a 16-bit memory.
- R3: Accesses run low part first. On a 16-bit memory the first memAddr is reqAddr with bit 0 cleared, and each following access adds 2. On an 8-bit memory the first memAddr is reqAddr, and each following access adds 1.
- R4: Full-width writes set memLaneN to 2'b00, which enables both lanes; lane bit 0 is the low byte. Access k of a 16-bit memory carries bus write bits [16k+15:16k]. Access k of an 8-bit memory carries bus byte k in memWdata[7:0], with memWdata[15:8] set to zero.
- R5: An 8-bit write to a 16-bit memory is one access. The byte appears in both halves of memWdata. memLaneN is 2'b10 when reqAddr[0] = 0 and 2'b01 when reqAddr[0] = 1.
- R6: Reads drive memLaneN = 2'b00 and memWrite = 0. Read data is assembled little-endian and unused high bits return 0. In an 8-bit read from a 16-bit memory, reqAddr[0] selects the lane returned in respRdata[7:0]. On an 8-bit memory only memRdata[7:0] is used.
- R7: memValid holds memAddr and memWdata steady until memAck. respValid rises for exactly one cycle, in the cycle after the final acknowledge. reqReady is 0 from the cycle after acceptance until the cycle after respValid.
- R8: NOR flash (memType 0) needs memWide = 1. In asynchronous mode it supports reads of all sizes and 16- and 32-bit writes. In synchronous mode (syncMode = 1) it supports only 16- and 32-bit reads.
- R9: PSRAM (memType 1) needs memWide = 1. In asynchronous mode it supports all sizes, read and write. In synchronous mode it supports 16- and 32-bit reads and writes of all sizes.
- R10: SRAM/ROM (memType 2) supports every size, read and write, at either width, but only in asynchronous mode.
- R11: Some transfers are unsupported: those outside R8 to R10, those with size code 3, and those with memType 3. Such a transfer gives respValid = 1 with respErr = 1 in the cycle after acceptance, drives no memValid, and raises reqReady again one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Bus transfer request |
| reqReady | output | 1 | High while idle; a request is taken when both are high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 = 8, 1 = 16, 2 = 32 bits |
| reqAddr | input | ADDR_W | Byte address of the transfer |
| reqWdata | input | 32 | Bus write data, little-endian |
| memType | input | 2 | 0 NOR flash, 1 PSRAM, 2 SRAM/ROM |
| syncMode | input | 1 | 1 = synchronous memory mode |
| memWide | input | 1 | 1 = 16-bit memory, 0 = 8-bit memory |
| respValid | output | 1 | One-cycle completion pulse |
| respErr | output | 1 | Unsupported transfer, valid with respValid |
| respRdata | output | 32 | Assembled read data, valid with respValid |
| memValid | output | 1 | External access request |
| memWrite | output | 1 | External access direction |
| memAddr | output | ADDR_W | External byte address |
| memWdata | output | 16 | External write data |
| memLaneN | output | 2 | Active-low byte-lane enables |
| memAck | input | 1 | Access completes in this cycle |
| memRdata | input | 16 | External read data, sampled with memAck |

## Verification
Suppose the sub-access index or the captured request goes wrong. Then memAddr, memWdata or memLaneN differ from the expected sequence in the very cycle the faulty access is presented. A wrong access count shows up one cycle after the last expected acknowledge, as a memValid that stays high or a respValid that comes early. A wrong support decode shows up in the cycle after acceptance, as a memValid where an error pulse belonged or the reverse. A read byte captured into the wrong lane shows up only at respValid, so every read pattern reuses bytes that earlier writes placed at known positions.

// File: rtl/splitPkg.sv
package splitPkg;
  localparam int BUS_W    = 32;
  localparam int MEM_W    = 16;
  localparam int MAX_SUBS = BUS_W / 8;
  localparam int IDX_W    = $clog2(MAX_SUBS);
  localparam int HALVES   = BUS_W / MEM_W;

  // memory kind codes
  localparam logic [1:0] KIND_NOR   = 2'd0;
  localparam logic [1:0] KIND_PSRAM = 2'd1;
  localparam logic [1:0] KIND_SRAM  = 2'd2;

  typedef struct packed {
    logic clear;  // any accepted request: wipe read collector
    logic load;   // supported request: capture into datapath
    logic step;   // external access acknowledged
  } dpCtl_t;

  function automatic logic comboOk(input logic [1:0] kind, input logic sync,
                                   input logic wide, input logic wr,
                                   input logic [1:0] size);
    logic ok;
    ok = 1'b0;
    if (size != 2'd3) begin
      case (kind)
        KIND_NOR:   ok = wide && (sync ? (!wr && size != 2'd0) : !(wr && size == 2'd0));
        KIND_PSRAM: ok = wide && (sync ? (wr || size != 2'd0) : 1'b1);
        KIND_SRAM:  ok = !sync;
        default:    ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

  function automatic logic [IDX_W:0] subCount(input logic [1:0] size, input logic wide);
    logic [IDX_W:0] bytes;
    bytes = (IDX_W+1)'(1) << size;
    if (!wide) return bytes;
    return (bytes > 1) ? (bytes >> 1) : (IDX_W+1)'(1);
  endfunction
endpackage

// File: rtl/splitCtrl.sv
module splitCtrl
  import splitPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqSize,
  input  logic [1:0] memType,
  input  logic       syncMode,
  input  logic       memWide,
  input  logic       memAck,
  input  logic       lastSub,
  output logic       reqReady,
  output logic       memValid,
  output logic       respValid,
  output logic       respErr,
  output dpCtl_t     ctl
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_RESP} state_e;
  state_e stateQ;
  logic errQ;
  logic accept, ok;

  assign accept = reqValid && (stateQ == ST_IDLE);
  assign ok     = comboOk(memType, syncMode, memWide, reqWrite, reqSize);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errQ   <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: if (accept) begin
          stateQ <= ok ? ST_BUSY : ST_RESP;
          errQ   <= !ok;
        end
        ST_BUSY: if (memAck && lastSub) stateQ <= ST_RESP;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign reqReady  = (stateQ == ST_IDLE);
  assign memValid  = (stateQ == ST_BUSY);
  assign respValid = (stateQ == ST_RESP);
  assign respErr   = respValid && errQ;

  always_comb begin
    ctl.clear = accept;
    ctl.load  = accept && ok;
    ctl.step  = (stateQ == ST_BUSY) && memAck;
  end
endmodule

// File: rtl/splitDatapath.sv
module splitDatapath
  import splitPkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]  reqWdata,
  input  logic              memWide,
  input  logic [MEM_W-1:0]  memRdata,
  output logic              lastSub,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [MEM_W-1:0]  memWdata,
  output logic [1:0]        memLaneN,
  output logic [BUS_W-1:0]  respRdata
);
  logic [ADDR_W-1:0] addrQ;
  logic [BUS_W-1:0]  wdataQ;
  logic [1:0]        sizeQ;
  logic              wideQ, writeQ;
  logic [IDX_W-1:0]  idxQ;
  logic [IDX_W:0]    cnt;
  logic [7:0]        wBytes [MAX_SUBS];
  logic [MEM_W-1:0]  wHalves [HALVES];
  logic [7:0]        accQ [MAX_SUBS];
  logic [7:0]        rdLo, rdHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      sizeQ  <= '0;
      wideQ  <= 1'b0;
      writeQ <= 1'b0;
      idxQ   <= '0;
    end else if (ctl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      sizeQ  <= reqSize;
      wideQ  <= memWide;
      writeQ <= reqWrite;
      idxQ   <= '0;
    end else if (ctl.step) begin
      idxQ   <= idxQ + 1'b1;
    end
  end

  assign cnt      = subCount(sizeQ, wideQ);
  assign lastSub  = ({1'b0, idxQ} == cnt - 1'b1);
  assign memWrite = writeQ;
  assign memAddr  = wideQ ? ({addrQ[ADDR_W-1:1], 1'b0} + (ADDR_W'(idxQ) << 1))
                          : (addrQ + ADDR_W'(idxQ));

  for (genvar g = 0; g < MAX_SUBS; g++) begin : gWrBytes
    assign wBytes[g] = wdataQ[8*g +: 8];
  end
  for (genvar h = 0; h < HALVES; h++) begin : gWrHalves
    assign wHalves[h] = wdataQ[MEM_W*h +: MEM_W];
  end

  always_comb begin
    memLaneN = 2'b00;
    if (!wideQ) begin
      memWdata = {8'h00, wBytes[idxQ]};
    end else if (sizeQ == 2'd0) begin
      memWdata = {2{wBytes[0]}};
      if (writeQ) memLaneN = addrQ[0] ? 2'b01 : 2'b10;
    end else begin
      memWdata = wHalves[idxQ[0]];
    end
  end

  assign rdLo = memRdata[7:0];
  assign rdHi = memRdata[15:8];

  for (genvar g = 0; g < MAX_SUBS; g++) begin : gRdLane
    logic hit;
    logic [7:0] src;
    always_comb begin
      if (!wideQ) begin
        hit = (idxQ == IDX_W'(g));
        src = rdLo;
      end else if (sizeQ == 2'd0) begin
        hit = (g == 0);
        src = addrQ[0] ? rdHi : rdLo;
      end else begin
        hit = (idxQ == IDX_W'(g / 2));
        src = (g % 2 == 1) ? rdHi : rdLo;
      end
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             accQ[g] <= '0;
      else if (ctl.clear)                    accQ[g] <= '0;
      else if (ctl.step && !writeQ && hit)   accQ[g] <= src;
    end
    assign respRdata[8*g +: 8] = accQ[g];
  end
endmodule

// File: rtl/extWidthSplitter.sv
module extWidthSplitter
  import splitPkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [1:0]        memType,
  input  logic              syncMode,
  input  logic              memWide,
  output logic              respValid,
  output logic              respErr,
  output logic [31:0]       respRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  output logic [1:0]        memLaneN,
  input  logic              memAck,
  input  logic [15:0]       memRdata
);
  dpCtl_t ctl;
  logic   lastSub;

  splitCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .memType(memType), .syncMode(syncMode),
    .memWide(memWide), .memAck(memAck), .lastSub(lastSub),
    .reqReady(reqReady), .memValid(memValid), .respValid(respValid),
    .respErr(respErr), .ctl(ctl)
  );

  splitDatapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memWide(memWide), .memRdata(memRdata), .lastSub(lastSub),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memLaneN(memLaneN), .respRdata(respRdata)
  );
endmodule

// File: rtl/extWidthSplitterChk.sv
module extWidthSplitterChk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              respValid,
  input logic              respErr,
  input logic              memValid,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [15:0]       memWdata,
  input logic [1:0]        memLaneN,
  input logic              memAck
);
  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memAck |=> memValid && $stable(memAddr) && $stable(memWdata));

  assert_resp_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid && reqReady);

  assert_idle_no_access_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memValid);

  assert_err_right_after_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    respErr |-> $past(reqValid && reqReady));

  assert_access_follows_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memValid) |-> $past(reqValid && reqReady));

  assert_ascending_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(memValid && memAck) && memValid |-> memAddr > $past(memAddr));

  assert_read_lanes_R6: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memWrite |-> memLaneN == 2'b00);
endmodule

bind extWidthSplitter extWidthSplitterChk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .respValid(respValid), .respErr(respErr), .memValid(memValid),
  .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
  .memLaneN(memLaneN), .memAck(memAck)
);

// File: tb/extWidthSplitter_tb.sv
`timescale 1ns/1ps
module extWidthSplitter_tb_top;
  localparam int ADDR_W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, syncMode = 1'b0, memWide = 1'b1;
  logic [1:0] reqSize = '0, memType = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic memAck = 1'b0;
  logic [15:0] memRdata = '0;
  logic reqReady, respValid, respErr, memValid, memWrite;
  logic [31:0] respRdata;
  logic [ADDR_W-1:0] memAddr;
  logic [15:0] memWdata;
  logic [1:0] memLaneN;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] bmem [256];

  always #2.5 clk = ~clk;

  extWidthSplitter #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memType(memType), .syncMode(syncMode),
    .memWide(memWide), .respValid(respValid), .respErr(respErr),
    .respRdata(respRdata), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memLaneN(memLaneN),
    .memAck(memAck), .memRdata(memRdata)
  );

  task automatic chk(input bit cond, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit refOk(bit wr, int size, int kind, bit sync, bit wide);
    if (size > 2 || kind > 2) return 0;
    if (kind == 2) return !sync;
    if (!wide) return 0;
    if (kind == 0) begin
      if (sync) return !wr && size > 0;
      return !(wr && size == 0);
    end
    if (sync) return wr || size > 0;
    return 1;
  endfunction

  function automatic string kindTag(int kind);
    if (kind == 0) return "R8";
    if (kind == 1) return "R9";
    return "R10";
  endfunction

  task automatic xfer(input bit wr, input int size, input int kind, input bit sync,
                      input bit wide, input int addr, input logic [31:0] wd);
    bit ok;
    int n, nbytes;
    logic [31:0] expR;
    @(negedge clk);
    chk(reqReady == 1'b1, "R7", "reqReady before request", reqReady, 1);
    reqValid = 1; reqWrite = wr; reqSize = 2'(size); memType = 2'(kind);
    syncMode = sync; memWide = wide; reqAddr = ADDR_W'(addr); reqWdata = wd;
    @(negedge clk);
    reqValid = 0; reqWdata = 32'hDEAD_BEEF; reqAddr = '1;
    ok = refOk(wr, size, kind, sync, wide);
    if (!ok) begin
      chk(respValid && respErr, "R11", "error pulse", {respValid, respErr}, 3);
      chk(memValid == 1'b0, "R11", "no access on error", memValid, 0);
      chk(reqReady == 1'b0, "R11", "busy during error resp", reqReady, 0);
      @(negedge clk);
      chk(reqReady && !respValid && !memValid, "R11", "idle after error",
          {reqReady, respValid, memValid}, 4);
      return;
    end
    nbytes = 1 << size;
    n = wide ? ((nbytes > 1) ? nbytes / 2 : 1) : nbytes;
    expR = '0;
    for (int i = 0; i < nbytes; i++) expR[8*i +: 8] = bmem[(addr + i) & 255];
    for (int k = 0; k < n; k++) begin
      int ea;
      logic [15:0] ed;
      logic [1:0] el;
      if (wide) begin
        ea = (addr & ~1) + 2 * k;
        if (size == 0) begin
          ed = {wd[7:0], wd[7:0]};
          el = wr ? ((addr & 1) ? 2'b01 : 2'b10) : 2'b00;
        end else begin
          ed = wd[16*k +: 16];
          el = 2'b00;
        end
      end else begin
        ea = addr + k;
        ed = {8'h00, wd[8*k +: 8]};
        el = 2'b00;
      end
      for (int w = 0; w <= (k % 2); w++) begin
        chk(memValid == 1'b1, "R2", "memValid during access", memValid, 1);
        chk(memAddr == ADDR_W'(ea), "R3", "sub-access address", memAddr, ea);
        chk(memWrite == wr, wr ? "R4" : "R6", "direction", memWrite, wr);
        if (wr) begin
          chk(memWdata == ed, (wide && size == 0) ? "R5" : "R4", "write data", memWdata, ed);
          chk(memLaneN == el, (wide && size == 0) ? "R5" : "R4", "lane enables", memLaneN, el);
        end else begin
          chk(memLaneN == 2'b00, "R6", "read lanes", memLaneN, 0);
        end
        chk(reqReady == 1'b0 && respValid == 1'b0, "R7", "busy while accessing",
            {reqReady, respValid}, 0);
        memRdata = wide ? {bmem[(ea + 1) & 255], bmem[ea & 255]} : {8'hA5, bmem[ea & 255]};
        memAck = (w == (k % 2));
        if (memAck && wr) begin
          if (!wide) bmem[ea & 255] = ed[7:0];
          else begin
            if (!el[0]) bmem[ea & 255] = ed[7:0];
            if (!el[1]) bmem[(ea + 1) & 255] = ed[15:8];
          end
        end
        @(negedge clk);
      end
      memAck = 0;
    end
    chk(memValid == 1'b0, "R2", "no extra access", memValid, 0);
    chk(respValid == 1'b1, "R7", "resp after final ack", respValid, 1);
    chk(respErr == 1'b0, kindTag(kind), "supported combo no error", respErr, 0);
    chk(reqReady == 1'b0, "R7", "busy during resp", reqReady, 0);
    if (!wr) chk(respRdata == expR, "R6", "read data", respRdata, expR);
    @(negedge clk);
    chk(respValid == 1'b0 && reqReady == 1'b1, "R7", "single resp then idle",
        {respValid, reqReady}, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 7 + 3);
    #1;
    chk(reqReady == 1'b1 && memValid == 1'b0 && respValid == 1'b0, "R1", "reset outputs",
        {reqReady, memValid, respValid}, 4);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(reqReady == 1'b1 && memValid == 1'b0 && respValid == 1'b0, "R1", "after reset",
        {reqReady, memValid, respValid}, 4);

    // R10 SRAM, 16-bit memory
    xfer(0, 0, 2, 0, 1, 'h11, '0);
    xfer(0, 0, 2, 0, 1, 'h10, '0);
    xfer(0, 1, 2, 0, 1, 'h12, '0);
    xfer(0, 2, 2, 0, 1, 'h20, '0);
    xfer(1, 0, 2, 0, 1, 'h31, 32'h0000_00C3);
    xfer(1, 0, 2, 0, 1, 'h30, 32'h0000_005A);
    xfer(1, 1, 2, 0, 1, 'h32, 32'h0000_B00F);
    xfer(1, 2, 2, 0, 1, 'h40, 32'h1234_5678);
    xfer(0, 2, 2, 0, 1, 'h30, '0);
    xfer(0, 2, 2, 0, 1, 'h40, '0);
    xfer(0, 0, 2, 0, 1, 'h43, '0);
    // R10 SRAM, 8-bit memory
    xfer(0, 2, 2, 0, 0, 'h50, '0);
    xfer(0, 1, 2, 0, 0, 'h56, '0);
    xfer(0, 0, 2, 0, 0, 'h59, '0);
    xfer(1, 2, 2, 0, 0, 'h60, 32'hCAFE_F00D);
    xfer(1, 1, 2, 0, 0, 'h66, 32'h0000_9876);
    xfer(1, 0, 2, 0, 0, 'h69, 32'h0000_0077);
    xfer(0, 2, 2, 0, 0, 'h60, '0);
    xfer(0, 2, 2, 0, 1, 'h64, '0);
    xfer(0, 2, 2, 0, 0, 'h66, '0);
    // R8 NOR flash
    xfer(0, 0, 0, 0, 1, 'h71, '0);
    xfer(0, 2, 0, 0, 1, 'h74, '0);
    xfer(1, 1, 0, 0, 1, 'h78, 32'h0000_4321);
    xfer(1, 2, 0, 0, 1, 'h7C, 32'h8765_ABCD);
    xfer(1, 0, 0, 0, 1, 'h80, 32'h0000_00FF);
    xfer(0, 2, 0, 0, 1, 'h7C, '0);
    xfer(0, 1, 0, 0, 0, 'h80, '0);
    xfer(0, 1, 0, 1, 1, 'h78, '0);
    xfer(0, 2, 0, 1, 1, 'h7C, '0);
    xfer(0, 0, 0, 1, 1, 'h79, '0);
    xfer(1, 1, 0, 1, 1, 'h78, 32'h0000_1111);
    // R9 PSRAM
    xfer(1, 0, 1, 0, 1, 'h91, 32'h0000_00E1);
    xfer(0, 2, 1, 0, 1, 'h90, '0);
    xfer(0, 0, 1, 1, 1, 'h90, '0);
    xfer(1, 0, 1, 1, 1, 'h94, 32'h0000_0042);
    xfer(1, 2, 1, 1, 1, 'h98, 32'h0BAD_CAFE);
    xfer(1, 1, 1, 1, 1, 'h96, 32'h0000_3C3C);
    xfer(0, 2, 1, 1, 1, 'h94, '0);
    xfer(0, 2, 1, 1, 1, 'h98, '0);
    xfer(0, 2, 1, 0, 0, 'h90, '0);
    // R11 other unsupported forms
    xfer(0, 1, 2, 1, 1, 'h10, '0);
    xfer(0, 3, 2, 0, 1, 'h10, '0);
    xfer(1, 1, 3, 0, 1, 'h10, 32'h1);
    xfer(0, 2, 2, 0, 1, 'h40, '0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule